// File: doc/BRIEF.md
# Paged Memory-Reference Execution Unit

This block executes the six memory-reference instructions of a 12-bit word machine with a 15-bit address space (a 3-bit field above a 12-bit offset). A start strobe hands it the current program counter and an instruction word. The unit then forms the operand address, fetches a pointer word for indirect references, performs the operation, and reports the following program counter together with a one-cycle completion pulse.

The unit owns the accumulator and the link bit. It reaches memory through a single synchronous request/acknowledge port, one word per access.

The operand address uses only the low seven bits of the instruction. A page-select bit places them either in page zero or in the page that holds the program counter. The address always stays inside the field of the program counter.

An indirect bit adds exactly one extra read. The word read there becomes the final 12-bit offset within the same field.

Top module: `mri_exec_unit`

## Requirements
- R1: After reset the accumulator and link read 0, and memReq and done are low.
- R2: The operand address is the PC field concatenated with a 12-bit offset. The offset's low 7 bits are instruction bits 6..0. Its upper 5 bits are PC bits 11..7 when instruction bit 7 is 1, and zero when it is 0.
- R3: When instruction bit 8 is 1, one read at the R2 address returns a word, and that word, within the PC field, replaces the operand address. Exactly one such extra read occurs.
- R4: Opcode 0 (instruction bits 11..9) ANDs the operand into the accumulator and leaves the link unchanged.
- R5: Opcode 1 adds the operand to the accumulator modulo 4096 and inverts the link when the sum carries out of bit 11; otherwise the link is unchanged.
- R6: Opcode 2 writes operand+1 modulo 4096 back to the same address. If that value is zero, nextPc advances by 2 instead of 1. The accumulator is unchanged.
- R7: Opcode 3 writes the accumulator to the operand address, then clears the accumulator.
- R8: Opcode 4 writes the low 12 bits of PC+1 to the target address, and nextPc becomes target+1.
- R9: Opcode 5 makes nextPc the target address, with no memory access besides an indirect read.
- R10: Every nextPc step wraps within the low 12 bits and keeps the PC field unchanged.
- R11: A request stays asserted, with a stable address and direction, until memAck. Each access completes exactly once, however long acknowledge is delayed.
- R12: done is a single-cycle pulse at the end of each instruction. Opcodes 6 and 7 finish with no memory access, an unchanged accumulator, and nextPc = PC+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin an instruction (taken when idle) |
| pcIn | input | 15 | Address of the instruction being executed |
| instWord | input | 12 | Instruction word |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 15 | Access address |
| memWdata | output | 12 | Write data |
| memAck | input | 1 | Access completes on this edge |
| memRdata | input | 12 | Read data, valid with memAck |
| done | output | 1 | Instruction finished |
| nextPc | output | 15 | Address of the next instruction |
| accOut | output | 12 | Accumulator |
| linkOut | output | 1 | Link bit |

## Verification
Addressing is tried with page-zero and current-page references from a nonzero field. This separates the two sources of the upper offset bits and shows that the field survives into the address. An indirect reference to a pointer in another page confirms that exactly two reads occur and that the second uses the pointer word.

The arithmetic is tried with sums that do and do not carry, so that link inversion is distinguished from link setting. Increment-and-skip is tried with a result of zero and a nonzero result. Program counters at the top of a page and at the top of a field expose any carry into the field. A stretched acknowledge separates a request held correctly from one that repeats or drops its access.

// File: rtl/mri_pkg.sv
package mri_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_TAD  = 3'd1,
    OP_ISZ  = 3'd2,
    OP_DCA  = 3'd3,
    OP_JMS  = 3'd4,
    OP_JMP  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } mri_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_IND   = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } mri_state_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic ldInst;   // capture instruction, PC and first address
    logic ldFinal;  // pointer word becomes the final address
    logic rdDone;   // operand read finished
    logic wrDone;   // write-back finished
  } mri_strobe_t;

endpackage

// File: rtl/mri_ctrl.sv
module mri_ctrl
  import mri_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [2:0]  opIn,
  input  logic        indIn,
  input  logic        memAck,
  output logic        memReq,
  output logic        memWe,
  output logic        done,
  output mri_strobe_t strobe
);

  mri_state_e state, stNext;
  mri_op_e    opQ;

  function automatic mri_state_e routeOp(input mri_op_e op);
    case (op)
      OP_AND, OP_TAD, OP_ISZ: routeOp = ST_READ;
      OP_DCA, OP_JMS:         routeOp = ST_WRITE;
      default:                routeOp = ST_DONE;
    endcase
  endfunction

  always_comb begin
    stNext = state;
    strobe = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    done   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.ldInst = 1'b1;
          if (opIn[2:1] == 2'b11) stNext = ST_DONE;
          else if (indIn)         stNext = ST_IND;
          else                    stNext = routeOp(mri_op_e'(opIn));
        end
      end
      ST_IND: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.ldFinal = 1'b1;
          stNext = routeOp(opQ);
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.rdDone = 1'b1;
          stNext = (opQ == OP_ISZ) ? ST_WRITE : ST_DONE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.wrDone = 1'b1;
          stNext = ST_DONE;
        end
      end
      ST_DONE: begin
        done   = 1'b1;
        stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_AND;
    end else begin
      state <= stNext;
      if (strobe.ldInst) opQ <= mri_op_e'(opIn);
    end
  end

endmodule

// File: rtl/mri_datapath.sv
module mri_datapath
  import mri_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int WORD_W  = 12,
  parameter int OFF_W   = 7,
  localparam int ADDR_W = FIELD_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mri_strobe_t       strobe,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [WORD_W-1:0] instWord,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] accOut,
  output logic              linkOut,
  output logic [ADDR_W-1:0] nextPc
);

  localparam int PAGE_W   = WORD_W - OFF_W;
  localparam int IND_BIT  = OFF_W + 1;
  localparam int PAGE_BIT = OFF_W;

  logic [FIELD_W-1:0] fieldQ;
  logic [WORD_W-1:0]  pcLowQ, addrQ, dataQ, accQ, nextLowQ;
  logic               linkQ;
  mri_op_e            opQ;

  logic [WORD_W-1:0]  eaIn;
  logic [PAGE_W-1:0]  pageBits;
  mri_op_e            opIn;
  logic [WORD_W:0]    sumWide;

  assign opIn     = mri_op_e'(instWord[WORD_W-1 -: 3]);
  assign pageBits = instWord[PAGE_BIT] ? pcIn[WORD_W-1:OFF_W] : '0;
  assign eaIn     = {pageBits, instWord[OFF_W-1:0]};
  assign sumWide  = {1'b0, accQ} + {1'b0, memRdata};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldQ   <= '0;
      pcLowQ   <= '0;
      addrQ    <= '0;
      dataQ    <= '0;
      accQ     <= '0;
      linkQ    <= 1'b0;
      nextLowQ <= '0;
      opQ      <= OP_AND;
    end else begin
      if (strobe.ldInst) begin
        fieldQ <= pcIn[ADDR_W-1:WORD_W];
        pcLowQ <= pcIn[WORD_W-1:0];
        opQ    <= opIn;
        addrQ  <= eaIn;
        if (opIn == OP_JMP && !instWord[IND_BIT])
          nextLowQ <= eaIn;
        else
          nextLowQ <= pcIn[WORD_W-1:0] + WORD_W'(1);
      end
      if (strobe.ldFinal) begin
        addrQ <= memRdata;
        if (opQ == OP_JMP) nextLowQ <= memRdata;
      end
      if (strobe.rdDone) begin
        case (opQ)
          OP_AND: accQ <= accQ & memRdata;
          OP_TAD: begin
            accQ  <= sumWide[WORD_W-1:0];
            linkQ <= linkQ ^ sumWide[WORD_W];
          end
          OP_ISZ: dataQ <= memRdata + WORD_W'(1);
          default: ;
        endcase
      end
      if (strobe.wrDone) begin
        case (opQ)
          OP_DCA: accQ <= '0;
          OP_ISZ: if (dataQ == '0) nextLowQ <= nextLowQ + WORD_W'(1);
          OP_JMS: nextLowQ <= addrQ + WORD_W'(1);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (opQ)
      OP_DCA:  memWdata = accQ;
      OP_ISZ:  memWdata = dataQ;
      OP_JMS:  memWdata = pcLowQ + WORD_W'(1);
      default: memWdata = '0;
    endcase
  end

  assign memAddr = {fieldQ, addrQ};
  assign nextPc  = {fieldQ, nextLowQ};
  assign accOut  = accQ;
  assign linkOut = linkQ;

endmodule

// File: rtl/mri_exec_unit.sv
module mri_exec_unit
  import mri_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int WORD_W  = 12,
  parameter int OFF_W   = 7,
  localparam int ADDR_W = FIELD_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [WORD_W-1:0] instWord,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRdata,
  output logic              done,
  output logic [ADDR_W-1:0] nextPc,
  output logic [WORD_W-1:0] accOut,
  output logic              linkOut
);

  mri_strobe_t strobe;

  mri_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .opIn     (instWord[WORD_W-1 -: 3]),
    .indIn    (instWord[OFF_W+1]),
    .memAck   (memAck),
    .memReq   (memReq),
    .memWe    (memWe),
    .done     (done),
    .strobe   (strobe)
  );

  mri_datapath #(
    .FIELD_W (FIELD_W),
    .WORD_W  (WORD_W),
    .OFF_W   (OFF_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pcIn     (pcIn),
    .instWord (instWord),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .accOut   (accOut),
    .linkOut  (linkOut),
    .nextPc   (nextPc)
  );

endmodule

// File: rtl/mri_exec_checker.sv
module mri_exec_checker #(
  parameter int FIELD_W = 3,
  parameter int WORD_W  = 12,
  localparam int ADDR_W = FIELD_W + WORD_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [ADDR_W-1:0] pcIn,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              done,
  input logic [ADDR_W-1:0] nextPc,
  input logic [WORD_W-1:0] accOut,
  input logic              linkOut
);

  logic               busyQ;
  logic [FIELD_W-1:0] fieldQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      fieldQ <= '0;
    end else if (startReq && !busyQ) begin
      busyQ  <= 1'b1;
      fieldQ <= pcIn[ADDR_W-1:WORD_W];
    end else if (done) begin
      busyQ  <= 1'b0;
    end
  end

  AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);                                                    // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                      // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> !memReq);                                                  // R12
  AST_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[ADDR_W-1:WORD_W] == fieldQ));                     // R2
  AST_PC_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (nextPc[ADDR_W-1:WORD_W] == fieldQ));                        // R10

endmodule

bind mri_exec_unit mri_exec_checker #(.FIELD_W(FIELD_W), .WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .pcIn(pcIn),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memAck(memAck),
  .done(done), .nextPc(nextPc), .accOut(accOut), .linkOut(linkOut)
);

// File: tb/sim_mri_exec_unit.sv
`timescale 1ns/1ps
module sim_mri_exec_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [14:0] pcIn = '0;
  logic [11:0] instWord = '0;
  logic        memReq, memWe, done, linkOut;
  logic [14:0] memAddr, nextPc;
  logic [11:0] memWdata, accOut;
  logic        memAck = 1'b0;
  logic [11:0] memRdata = '0;

  always #10 clk = ~clk;

  mri_exec_unit u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pcIn(pcIn), .instWord(instWord),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .done(done), .nextPc(nextPc),
    .accOut(accOut), .linkOut(linkOut)
  );

  int testsRun = 0;
  int testsFailed = 0;

  logic [11:0] mem [0:4095];
  int          rdCnt = 0, wrCnt = 0, holdCnt = 0;
  logic [14:0] firstRd, lastRd, lastWrAddr;
  logic [11:0] lastWrData;
  logic        reqS = 1'b0, ackS = 1'b0, weS = 1'b0;
  logic [14:0] addrS = '0;
  logic [11:0] wdS = '0;
  int          rdBase;
  int          nRd, nWr, lastCycles;

  localparam logic [14:0] PCB = 15'o00200;

  // memory model: transfers complete on the edge where req and ack were both high
  always @(negedge clk) begin
    if (reqS && ackS) begin
      if (weS) begin
        mem[addrS[11:0]] = wdS;
        wrCnt = wrCnt + 1;
        lastWrAddr = addrS;
        lastWrData = wdS;
      end else begin
        rdCnt = rdCnt + 1;
        if (rdCnt == rdBase + 1) firstRd = addrS;
        lastRd = addrS;
      end
    end
    reqS  = memReq;
    addrS = memAddr;
    weS   = memWe;
    wdS   = memWdata;
    if (memReq && holdCnt > 0) begin
      memAck  = 1'b0;
      holdCnt = holdCnt - 1;
    end else begin
      memAck = memReq;
    end
    ackS     = memAck;
    memRdata = mem[memAddr[11:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int op, input bit ind, input bit pg, input logic [6:0] off);
    return {3'(op), ind, pg, off};
  endfunction

  task automatic runInst(input logic [14:0] pc, input logic [11:0] inst);
    int wr0;
    bit seen;
    rdBase = rdCnt;
    wr0 = wrCnt;
    seen = 1'b0;
    @(negedge clk);
    pcIn = pc;
    instWord = inst;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    lastCycles = 0;
    for (int c = 0; c < 64; c++) begin
      #1;
      if (done) begin
        seen = 1'b1;
        break;
      end
      lastCycles++;
      @(negedge clk);
    end
    if (!seen) chk(1'b0, "watchdog", 0, 1);
    @(negedge clk);
    nRd = rdCnt - rdBase;
    nWr = wrCnt - wr0;
  endtask

  task automatic setAcc(input logic [11:0] v);
    runInst(PCB, mk(3, 0, 0, 7'o100));
    mem[12'o0101] = v;
    runInst(PCB, mk(1, 0, 0, 7'o101));
  endtask

  task automatic setLink(input bit l);
    if (linkOut != l) begin
      setAcc(12'o7777);
      mem[12'o0102] = 12'o0001;
      runInst(PCB, mk(1, 0, 0, 7'o102));
    end
  endtask

  task automatic testReset();
    chk(accOut == 0, "R1 acc", accOut, 0);
    chk(linkOut == 0, "R1 link", linkOut, 0);
    chk(memReq == 0 && done == 0, "R1 req/done", {memReq, done}, 0);
  endtask

  task automatic testPageZero();
    setAcc(12'o0000);
    mem[12'o0020] = 12'o0017;
    runInst(15'o23456, mk(1, 0, 0, 7'o020));
    chk(firstRd == 15'o20020, "R2 page zero addr", firstRd, 15'o20020);
    chk(accOut == 12'o0017, "R2 page zero data", accOut, 12'o0017);
  endtask

  task automatic testCurPage();
    mem[12'o3405] = 12'o0001;
    runInst(15'o23456, mk(1, 0, 1, 7'o005));
    chk(firstRd == 15'o23405, "R2 current page addr", firstRd, 15'o23405);
    chk(accOut == 12'o0020, "R2 current page data", accOut, 12'o0020);
  endtask

  task automatic testIndirect();
    setAcc(12'o7777);
    mem[12'o0030] = 12'o1234;
    mem[12'o1234] = 12'o0770;
    runInst(15'o10200, mk(0, 1, 0, 7'o030));
    chk(nRd == 2, "R3 read count", nRd, 2);
    chk(firstRd == 15'o10030, "R3 pointer addr", firstRd, 15'o10030);
    chk(lastRd == 15'o11234, "R3 final addr", lastRd, 15'o11234);
    chk(accOut == 12'o0770, "R3 operand", accOut, 12'o0770);
  endtask

  task automatic testAnd();
    setLink(1'b1);
    setAcc(12'o7070);
    mem[12'o0040] = 12'o1717;
    runInst(PCB, mk(0, 0, 0, 7'o040));
    chk(accOut == 12'o1010, "R4 and result", accOut, 12'o1010);
    chk(linkOut == 1'b1, "R4 link kept", linkOut, 1);
  endtask

  task automatic testTad();
    setLink(1'b0);
    setAcc(12'o7777);
    mem[12'o0041] = 12'o0001;
    runInst(PCB, mk(1, 0, 0, 7'o041));
    chk(accOut == 0 && linkOut == 1'b1, "R5 carry toggles", {linkOut, accOut}, 13'o10000);
    mem[12'o0041] = 12'o0123;
    runInst(PCB, mk(1, 0, 0, 7'o041));
    chk(accOut == 12'o0123 && linkOut == 1'b1, "R5 no carry", {linkOut, accOut}, 13'o10123);
    mem[12'o0041] = 12'o7700;
    runInst(PCB, mk(1, 0, 0, 7'o041));
    chk(accOut == 12'o0023 && linkOut == 1'b0, "R5 carry toggles back", {linkOut, accOut}, 13'o00023);
  endtask

  task automatic testIsz();
    setAcc(12'o0555);
    mem[12'o0042] = 12'o0005;
    runInst(PCB, mk(2, 0, 0, 7'o042));
    chk(mem[12'o0042] == 12'o0006 && nWr == 1, "R6 increment", mem[12'o0042], 12'o0006);
    chk(nextPc == 15'o00201, "R6 no skip", nextPc, 15'o00201);
    mem[12'o0042] = 12'o7777;
    runInst(PCB, mk(2, 0, 0, 7'o042));
    chk(mem[12'o0042] == 12'o0000, "R6 wrap to zero", mem[12'o0042], 0);
    chk(nextPc == 15'o00202, "R6 skip", nextPc, 15'o00202);
    chk(accOut == 12'o0555, "R6 acc kept", accOut, 12'o0555);
  endtask

  int dcaCycles;
  task automatic testDca();
    setAcc(12'o4321);
    runInst(PCB, mk(3, 0, 0, 7'o043));
    dcaCycles = lastCycles;
    chk(mem[12'o0043] == 12'o4321, "R7 stored", mem[12'o0043], 12'o4321);
    chk(accOut == 0, "R7 cleared", accOut, 0);
    chk(nWr == 1 && nRd == 0, "R11 single write", nWr, 1);
  endtask

  task automatic testStall();
    setAcc(12'o0246);
    holdCnt = 3;
    runInst(PCB, mk(3, 0, 0, 7'o044));
    chk(nWr == 1, "R11 stalled write once", nWr, 1);
    chk(mem[12'o0044] == 12'o0246, "R11 stalled data", mem[12'o0044], 12'o0246);
    chk(lastCycles == dcaCycles + 3, "R11 waits for ack", lastCycles, dcaCycles + 3);
  endtask

  task automatic testJms();
    runInst(15'o10200, mk(4, 0, 1, 7'o010));
    chk(lastWrAddr == 15'o10210 && lastWrData == 12'o0201, "R8 return stored", lastWrData, 12'o0201);
    chk(nextPc == 15'o10211, "R8 target+1", nextPc, 15'o10211);
  endtask

  task automatic testJmp();
    mem[12'o0050] = 12'o3333;
    runInst(15'o40200, mk(5, 1, 0, 7'o050));
    chk(nextPc == 15'o43333 && nRd == 1 && nWr == 0, "R9 indirect jump", nextPc, 15'o43333);
    runInst(15'o40200, mk(5, 0, 1, 7'o077));
    chk(nextPc == 15'o40277 && nRd == 0 && nWr == 0, "R9 direct jump", nextPc, 15'o40277);
  endtask

  task automatic testWrap();
    runInst(15'o37777, 12'o6000);
    chk(nextPc == 15'o30000, "R10 increment wrap", nextPc, 15'o30000);
    mem[12'o0045] = 12'o7777;
    runInst(15'o37777, mk(2, 0, 0, 7'o045));
    chk(nextPc == 15'o30001, "R10 skip wrap", nextPc, 15'o30001);
    runInst(15'o57777, mk(4, 0, 1, 7'o177));
    chk(lastWrAddr == 15'o57777 && lastWrData == 12'o0000, "R10 return wrap", lastWrData, 0);
    chk(nextPc == 15'o50000, "R10 target wrap", nextPc, 15'o50000);
  endtask

  task automatic testReserved();
    setAcc(12'o1111);
    runInst(15'o20300, 12'o7402);
    chk(nRd == 0 && nWr == 0, "R12 no access", nRd + nWr, 0);
    chk(accOut == 12'o1111 && nextPc == 15'o20301, "R12 acc and pc", nextPc, 15'o20301);
    chk(done == 1'b0, "R12 single pulse", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPageZero();
    testCurPage();
    testIndirect();
    testAnd();
    testTad();
    testIsz();
    testDca();
    testStall();
    testJms();
    testJmp();
    testWrap();
    testReserved();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 20);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule